// File: doc/BRIEF.md
# Match Timer with Posted Counter Clear

This block is a register-mapped up-counter that runs in its own timer clock while software reaches it over a simple single-cycle register bus in a separate bus clock. The timer clock passes through a small prescaler before it advances the counter. A programmable match value raises a one-cycle interrupt pulse when the count reaches it. An optional mode returns the count to zero on the tick after a match, which gives a periodic interrupt.

Clearing the counter is a posted operation. A write to the clear location starts a toggle handshake into the timer domain and returns at once. A status bit stays high until the timer domain has zeroed the count and its acknowledgement has come back. Software that must not re-arm the timer before the clear lands polls that bit. The count is read through a Gray-coded copy that is synchronized into the bus clock, so a read never returns a torn value.

Top module: `tick_match_timer`

## Requirements
- R1: After reset every readable location returns 0, the status pending bit is 0 and `irq_o` is low.
- R2: Only word-aligned writes with `bus_addr[1:0]==0` take effect; unaligned writes are ignored. The word map is: match at 0x00, count at 0x04 (read-only), control at 0x08 with run in bit 0 and restart-on-match in bit 1, clear at 0x0C (write-only, reads 0), divider code at 0x10 in bits [1:0], and status at 0x14. Match, control and divider read back as written, masked to their widths.
- R3: Any write to 0x0C sets the count to zero, whatever the write data.
- R4: Status bit 10 reads 1 from the cycle after a clear write until the clear has been applied in the timer clock and acknowledged back, then reads 0.
- R5: A clear written while one is pending is merged into it: no new request starts, and the pending bit falls once, with the count at zero.
- R6: While run is set the count goes up by one on each prescaler tick and wraps from its all-ones value to zero.
- R7: Divider codes 0, 1, 2 and 3 make the counter advance once every 1, 2, 3 and 4 timer clocks; any write to the divider location restarts the prescaler.
- R8: With run clear the count holds its value and no interrupt is raised, even when the count equals the match value.
- R9: `irq_o` pulses high for exactly one timer clock each time the count becomes equal to the match value while run is set. With restart off the count goes on past the match and the next pulse needs a wrap.
- R10: With restart-on-match set, the tick after the count equals the match value returns the count to zero. With match value M the period is M+1 ticks.
- R11: A count read while the counter is stopped returns exactly the timer-domain count, and repeated reads agree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed location (combinational) |
| tmr_clk | input | 1 | Timer input clock |
| tmr_rst_n | input | 1 | Asynchronous active-low reset, timer domain |
| irq_o | output | 1 | Rising-edge match interrupt, one timer clock wide |

## Verification
The bench builds the block with an 8-bit counter. This makes the wrap from 0xFF to 0, and a second match after the wrap, reachable within a few hundred ticks. The timer clock runs at exactly three bus periods with a fixed phase offset, so the enable and disable writes reach the timer domain with equal latency. A run of N timer clocks at divide-by-one therefore ends at exactly N. Runs at the larger divider codes are checked within one tick, because the prescaler phase relative to the enable edge is not pinned.

// File: rtl/mt_pkg.sv
package mt_pkg;

  localparam int DATA_W       = 32;
  localparam int STS_PEND_BIT = 10;

  // Word index of each bus location (byte address / 4)
  typedef enum logic [2:0] {
    RG_MATCH  = 3'd0,
    RG_COUNT  = 3'd1,
    RG_CTRL   = 3'd2,
    RG_CLEAR  = 3'd3,
    RG_DIV    = 3'd4,
    RG_STATUS = 3'd5
  } reg_idx_e;

  // bit 1: restart on match, bit 0: run
  typedef struct packed {
    logic restart;
    logic run;
  } ctrl_t;

  function automatic logic [31:0] gray_enc(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_dec(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // Next counter value; caller truncates to the counter width
  function automatic logic [31:0] count_step(
    input logic [31:0] cur,
    input logic [31:0] mval,
    input logic        run,
    input logic        tick,
    input logic        wrap_on_match,
    input logic        clr
  );
    if (clr) return 32'd0;
    if (!(run && tick)) return cur;
    if (wrap_on_match && (cur == mval)) return 32'd0;
    return cur + 32'd1;
  endfunction

endpackage

// File: rtl/mt_sync_bits.sv
module mt_sync_bits #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/mt_edge_sync.sv
module mt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);

  logic tog_s;
  logic tog_prev;

  mt_sync_bits #(.W(1), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (tog_in),
    .q     (tog_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_prev <= 1'b0;
    else        tog_prev <= tog_s;
  end

  assign pulse = tog_s ^ tog_prev;

endmodule

// File: rtl/mt_regs.sv
module mt_regs
  import mt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count_gray_s,
  input  logic              clr_ack_s,
  output logic [CNT_W-1:0]  match_q,
  output ctrl_t             ctrl_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              clr_tog,
  output logic              div_tog,
  output logic              clr_pend
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_en;
  logic [CNT_W-1:0] count_bin;

  assign idx   = bus_addr[ADDR_W-1:2];
  assign wr_en = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);

  // Posted clear: a request is outstanding while the toggles differ
  assign clr_pend = clr_tog ^ clr_ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      ctrl_q  <= '0;
      div_q   <= '0;
      clr_tog <= 1'b0;
      div_tog <= 1'b0;
    end else if (wr_en) begin
      if (idx == IDX_W'(RG_MATCH)) match_q <= bus_wdata[CNT_W-1:0];
      if (idx == IDX_W'(RG_CTRL))  ctrl_q  <= ctrl_t'(bus_wdata[1:0]);
      if (idx == IDX_W'(RG_DIV)) begin
        div_q   <= bus_wdata[DIV_W-1:0];
        div_tog <= ~div_tog;
      end
      if ((idx == IDX_W'(RG_CLEAR)) && !clr_pend) clr_tog <= ~clr_tog;
    end
  end

  assign count_bin = CNT_W'(gray_dec(32'(count_gray_s)));

  always_comb begin
    bus_rdata = '0;
    if (idx == IDX_W'(RG_MATCH))  bus_rdata = DATA_W'(match_q);
    if (idx == IDX_W'(RG_COUNT))  bus_rdata = DATA_W'(count_bin);
    if (idx == IDX_W'(RG_CTRL))   bus_rdata = DATA_W'(ctrl_q);
    if (idx == IDX_W'(RG_DIV))    bus_rdata = DATA_W'(div_q);
    if (idx == IDX_W'(RG_STATUS)) bus_rdata[STS_PEND_BIT] = clr_pend;
  end

endmodule

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] code,
  input  logic             restart,
  output logic             tick
);

  logic [DIV_W-1:0] phase_q;

  // code N gives one tick every N+1 clocks
  assign tick = (phase_q == code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (tick)    phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

endmodule

// File: rtl/mt_count_core.sv
module mt_count_core
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart_en,
  input  logic [CNT_W-1:0] match,
  input  logic             tick,
  input  logic             clr_pulse,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] gray_q,
  output logic             ack_tog,
  output logic             irq_o
);

  logic [CNT_W-1:0] count_d;
  logic             hit;
  logic             hit_q;

  assign hit     = run && (count_q == match);
  assign count_d = CNT_W'(count_step(32'(count_q), 32'(match), run, tick,
                                     restart_en, clr_pulse));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      gray_q  <= '0;
      hit_q   <= 1'b0;
      irq_o   <= 1'b0;
      ack_tog <= 1'b0;
    end else begin
      count_q <= count_d;
      gray_q  <= CNT_W'(gray_enc(32'(count_d)));
      hit_q   <= hit;
      irq_o   <= hit && !hit_q;
      if (clr_pulse) ack_tog <= ~ack_tog;
    end
  end

endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import mt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 5,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tmr_clk,
  input  logic              tmr_rst_n,
  output logic              irq_o
);

  // bus domain
  logic [CNT_W-1:0] match_q;
  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             clr_tog;
  logic             div_tog;
  logic             clr_pend;
  logic [CNT_W-1:0] gray_s;
  logic             ack_s;

  // timer domain
  logic [1:0]       ctrl_s;
  logic             run_t;
  logic             restart_t;
  logic             clr_pulse_t;
  logic             div_pulse_t;
  logic             tick_t;
  logic [CNT_W-1:0] count_t;
  logic [CNT_W-1:0] gray_t;
  logic             ack_tog_t;

  mt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk          (bus_clk),
    .rst_n        (bus_rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .count_gray_s (gray_s),
    .clr_ack_s    (ack_s),
    .match_q      (match_q),
    .ctrl_q       (ctrl_q),
    .div_q        (div_q),
    .clr_tog      (clr_tog),
    .div_tog      (div_tog),
    .clr_pend     (clr_pend)
  );

  // Control bits cross as quasi-static levels
  mt_sync_bits #(.W(2), .STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk   (tmr_clk),
    .rst_n (tmr_rst_n),
    .d     (ctrl_q),
    .q     (ctrl_s)
  );
  assign run_t     = ctrl_s[0];
  assign restart_t = ctrl_s[1];

  mt_edge_sync #(.STAGES(SYNC_STAGES)) u_clr_xing (
    .clk    (tmr_clk),
    .rst_n  (tmr_rst_n),
    .tog_in (clr_tog),
    .pulse  (clr_pulse_t)
  );

  mt_edge_sync #(.STAGES(SYNC_STAGES)) u_div_xing (
    .clk    (tmr_clk),
    .rst_n  (tmr_rst_n),
    .tog_in (div_tog),
    .pulse  (div_pulse_t)
  );

  mt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk     (tmr_clk),
    .rst_n   (tmr_rst_n),
    .code    (div_q),
    .restart (div_pulse_t),
    .tick    (tick_t)
  );

  mt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (tmr_clk),
    .rst_n      (tmr_rst_n),
    .run        (run_t),
    .restart_en (restart_t),
    .match      (match_q),
    .tick       (tick_t),
    .clr_pulse  (clr_pulse_t),
    .count_q    (count_t),
    .gray_q     (gray_t),
    .ack_tog    (ack_tog_t),
    .irq_o      (irq_o)
  );

  // Return paths into the bus clock
  mt_sync_bits #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (bus_clk),
    .rst_n (bus_rst_n),
    .d     (ack_tog_t),
    .q     (ack_s)
  );

  mt_sync_bits #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_gray_sync (
    .clk   (bus_clk),
    .rst_n (bus_rst_n),
    .d     (gray_t),
    .q     (gray_s)
  );

endmodule

// File: rtl/mt_checker.sv
module mt_checker
  import mt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              clr_pend,
  input logic              clr_tog,
  input logic              tmr_clk,
  input logic              tmr_rst_n,
  input logic              run_t,
  input logic              restart_t,
  input logic              tick_t,
  input logic              clr_pulse_t,
  input logic [CNT_W-1:0]  count_t,
  input logic [CNT_W-1:0]  match_q,
  input logic              irq_o
);

  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'({RG_CLEAR, 2'b00});
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  logic clr_wr;
  logic at_match;
  assign clr_wr   = bus_sel && bus_wr && (bus_addr == CLR_ADDR);
  assign at_match = (count_t == match_q);

  AST_PEND_AFTER_CLEAR: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (clr_wr && !clr_pend) |=> clr_pend); // R4

  AST_CLEAR_MERGED: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (clr_wr && clr_pend) |=> $stable(clr_tog)); // R5

  AST_CLEAR_ZEROES: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    clr_pulse_t |=> (count_t == '0)); // R3

  AST_STEP_ONE: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    (tick_t && run_t && !clr_pulse_t && !(restart_t && at_match))
      |=> (count_t == $past(count_t) + ONE)); // R6

  AST_HOLD_STOPPED: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    (!run_t && !clr_pulse_t) |=> $stable(count_t)); // R8

  AST_RESTART_ZERO: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    (tick_t && run_t && restart_t && at_match && !clr_pulse_t) |=> (count_t == '0)); // R10

  AST_IRQ_ONE_CYCLE: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    irq_o |=> !irq_o); // R9

  AST_IRQ_NEEDS_RUN: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    irq_o |-> $past(run_t)); // R8

endmodule

bind tick_match_timer mt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .bus_clk     (bus_clk),
  .bus_rst_n   (bus_rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .clr_pend    (clr_pend),
  .clr_tog     (clr_tog),
  .tmr_clk     (tmr_clk),
  .tmr_rst_n   (tmr_rst_n),
  .run_t       (run_t),
  .restart_t   (restart_t),
  .tick_t      (tick_t),
  .clr_pulse_t (clr_pulse_t),
  .count_t     (count_t),
  .match_q     (match_q),
  .irq_o       (irq_o)
);

// File: tb/tick_match_timer_tb_top.sv
module tick_match_timer_tb_top;

  localparam int CW = 8;
  localparam logic [4:0] A_MATCH = 5'h00, A_COUNT = 5'h04, A_CTRL = 5'h08,
                         A_CLEAR = 5'h0C, A_DIV = 5'h10, A_STAT = 5'h14;
  localparam logic [31:0] PEND = 32'h0000_0400;

  logic        bus_clk = 1'b0;
  logic        tmr_clk = 1'b0;
  logic        bus_rst_n = 1'b0;
  logic        tmr_rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  always #2 bus_clk = ~bus_clk;
  initial begin
    #1;
    forever #6 tmr_clk = ~tmr_clk;
  end

  tick_match_timer #(.CNT_W(CW)) dut_i (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tmr_clk   (tmr_clk),
    .tmr_rst_n (tmr_rst_n),
    .irq_o     (irq_o)
  );

  typedef struct {
    logic [4:0]  addr;
    logic [31:0] lo;
    logic [31:0] hi;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   irq_cnt = 0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] lo, input logic [31:0] hi);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h..0x%0h", tag, act, lo, hi);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // driver: queue the expectation, then issue the read
  task automatic bus_read(input logic [4:0] a, input logic [31:0] lo,
                          input logic [31:0] hi, input string tag);
    exp_t e;
    e.addr = a; e.lo = lo; e.hi = hi; e.tag = tag;
    sb_q.push_back(e);
    @(negedge bus_clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge bus_clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  // run for n timer clocks with the enable edges at a fixed timer phase
  task automatic run_ticks(input logic [31:0] ctl, input int n);
    @(posedge tmr_clk);
    bus_write(A_CTRL, ctl | 32'h1);
    repeat (n) @(posedge tmr_clk);
    bus_write(A_CTRL, ctl);
    idle(20);
  endtask

  task automatic clear_settle(input logic [31:0] d);
    bus_write(A_CLEAR, d);
    idle(40);
  endtask

  // monitor: pop and compare as read data appears
  always @(negedge bus_clk) begin
    #1;
    if (bus_sel && !bus_wr) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "unexpected read", bus_rdata, 32'h0, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check((bus_rdata >= e.lo) && (bus_rdata <= e.hi) && (bus_addr == e.addr),
              e.tag, bus_rdata, e.lo, e.hi);
      end
    end
  end

  always @(negedge tmr_clk) begin
    if (irq_o) irq_cnt++;
  end

  initial begin
    repeat (100000) @(posedge bus_clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    idle(10);
    check(irq_o == 1'b0, "R1 irq in reset", 32'(irq_o), 0, 0);
    bus_rst_n = 1'b1;
    tmr_rst_n = 1'b1;
    idle(5);

    // R1: reset values
    bus_read(A_MATCH, 0, 0, "R1 match reset");
    bus_read(A_COUNT, 0, 0, "R1 count reset");
    bus_read(A_CTRL,  0, 0, "R1 ctrl reset");
    bus_read(A_DIV,   0, 0, "R1 div reset");
    bus_read(A_STAT,  0, 0, "R1 status reset");

    // R2: map, masking, unaligned writes ignored
    bus_write(A_MATCH, 32'h1234_565A);
    bus_read(A_MATCH, 32'h5A, 32'h5A, "R2 match readback");
    bus_write(A_CTRL, 32'hFFFF_FFFE);
    bus_read(A_CTRL, 32'h2, 32'h2, "R2 ctrl readback");
    bus_write(A_DIV, 32'hFFFF_FFF6);
    bus_read(A_DIV, 32'h2, 32'h2, "R2 div readback");
    bus_read(A_CLEAR, 0, 0, "R2 clear reads zero");
    bus_write(5'h01, 32'h77);
    bus_read(A_MATCH, 32'h5A, 32'h5A, "R2 unaligned ignored");
    bus_write(A_CTRL, 32'h0);
    bus_write(A_DIV, 32'h0);
    bus_write(A_MATCH, 32'hFF);
    idle(20);

    // R6 / R11: exact count at divide by one, stable readback
    clear_settle(32'h0);
    run_ticks(32'h0, 37);
    bus_read(A_COUNT, 37, 37, "R6 count after 37 ticks");
    idle(30);
    bus_read(A_COUNT, 37, 37, "R11 stopped count stable");

    // R3: clear with arbitrary data
    clear_settle(32'hDEAD_BEEF);
    bus_read(A_COUNT, 0, 0, "R3 clear zeroes count");

    // R4: pending bit
    bus_write(A_CLEAR, 32'h0);
    bus_read(A_STAT, PEND, PEND, "R4 pending set");
    idle(40);
    bus_read(A_STAT, 0, 0, "R4 pending cleared");

    // R5: merged back-to-back clears
    run_ticks(32'h0, 20);
    bus_read(A_COUNT, 20, 20, "R6 count after 20 ticks");
    bus_write(A_CLEAR, 32'h1);
    bus_write(A_CLEAR, 32'h2);
    bus_read(A_STAT, PEND, PEND, "R5 pending during merge");
    idle(40);
    bus_read(A_STAT, 0, 0, "R5 pending falls");
    bus_read(A_COUNT, 0, 0, "R5 count zero after merge");
    run_ticks(32'h0, 5);
    bus_read(A_COUNT, 5, 5, "R5 counts normally after merge");

    // R6 wrap and R9 interrupts without restart
    clear_settle(32'h0);
    bus_write(A_MATCH, 32'h12);
    idle(10);
    base = irq_cnt;
    run_ticks(32'h0, 300);
    bus_read(A_COUNT, 44, 44, "R6 wrap 300 ticks");
    check(irq_cnt - base == 2, "R9 irq count across wrap", 32'(irq_cnt - base), 2, 2);

    // R8: stopped, match equals count
    base = irq_cnt;
    bus_write(A_MATCH, 32'h2C);
    idle(60);
    check(irq_cnt == base, "R8 no irq while stopped", 32'(irq_cnt - base), 0, 0);
    bus_read(A_COUNT, 44, 44, "R8 count held");

    // R10: restart on match, period match+1
    clear_settle(32'h0);
    bus_write(A_MATCH, 32'h9);
    idle(10);
    base = irq_cnt;
    run_ticks(32'h2, 45);
    bus_read(A_COUNT, 5, 5, "R10 restart count");
    check(irq_cnt - base == 4, "R10 periodic irq count", 32'(irq_cnt - base), 4, 4);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_MATCH, 32'hFF);

    // R7: divider codes
    bus_write(A_DIV, 32'h3);
    clear_settle(32'h0);
    run_ticks(32'h0, 40);
    bus_read(A_COUNT, 9, 11, "R7 divide by 4");
    bus_write(A_DIV, 32'h1);
    clear_settle(32'h0);
    run_ticks(32'h0, 40);
    bus_read(A_COUNT, 19, 21, "R7 divide by 2");
    bus_write(A_DIV, 32'h2);
    clear_settle(32'h0);
    run_ticks(32'h0, 30);
    bus_read(A_COUNT, 9, 11, "R7 divide by 3");

    idle(10);
    check(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 0, 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule